// File: doc/BRIEF.md
# Per-Processor Local Interrupt Router

This block is the per-core part of an interrupt controller. It collects seven level-sensitive interrupt sources that belong to one processor: watchdog, count/compare, core timer, performance counter, two software interrupts and the debug channel. It registers their levels as a pending vector, gates them with an enable mask, and steers each enabled source onto one of the processor's hardware interrupt lines through a per-source routing word. Watchdog counting, the debug channel and the performance counter are not modelled here; their inputs are plain levels.

Software reaches the block over a simple single-cycle register bus. The enable mask is changed only through write-one-to-set and write-one-to-clear words, so bits can be toggled without a read-modify-write. A control word carries the vectored-mode flag, which software may set or clear, and read-only flags that say which source groups can be routed.

Top module: `lic_local_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000001E, the mask reads 0, every routing word reads 0 and every interrupt line is low.
- R2: Source bit positions are watchdog 0, compare 1, timer 2, performance counter 3, software 0 at bit 4, software 1 at bit 5, debug channel 6. The pending word (offset 0x04) reads the source levels captured at the latest clock edge in those positions; writes to it have no effect.
- R3: A write to the set word (offset 0x10) sets each mask bit whose data bit in 6:0 is 1; data bits 31:7 are ignored.
- R4: A write to the clear word (offset 0x0C) clears each mask bit whose data bit in 6:0 is 1; data bits 31:7 are ignored.
- R5: The mask word (offset 0x08) is read-only; a write to it leaves the mask unchanged.
- R6: In the control word (offset 0x00), bit 0 is the vectored-mode flag and is the only writable bit; bits 4:1 are the routable flags for timer, performance counter, software pair and debug channel, and read as 1. The vectored flag does not alter line routing.
- R7: The routing word of source i sits at offset 0x40 + 4*i; bit 31 enables routing and bits 5:0 hold the line number; all other bits read as 0.
- R8: Line p is high exactly when some source is pending, enabled in the mask, has routing enabled and its line number resolves to p.
- R9: A line number above 5 resolves to line 5 (output bit p stands for processor interrupt p+2).
- R10: A change on a source input reaches the interrupt lines after exactly one rising clock edge.
- R11: A read returns its data on bus_rdata after the next rising edge; reads of unmapped or unaligned offsets, and of the set and clear words, return 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| src_lvl | input | 7 | Local source levels in the R2 bit order |
| cpu_irq | output | 6 | Processor interrupt lines, bit p is interrupt p+2 |

## Verification
Register writes take effect at the edge that accepts them, so mask or routing changes show on the lines one edge after the write, and read data is due one edge after the read strobe. Source levels pass one register before the lines, so the bench drives sources on the falling edge, confirms the lines are still unchanged at once, and compares them just after the following rising edge. All other comparisons are made on falling edges, half a cycle clear of every register update.

// File: rtl/lic_pkg.sv
package lic_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int NUM_SRC   = 7;
    localparam int SRC_IDX_W = $clog2(NUM_SRC);
    localparam int PIN_W     = 6;
    localparam int NUM_FLAGS = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PEND     = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MASK     = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CLR      = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_SET      = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_MAP_BASE = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_MAP_END  = OFS_MAP_BASE + ADDR_W'(4 * NUM_SRC);

    typedef enum logic [2:0] {
        SRC_WDOG  = 3'd0,
        SRC_CMP   = 3'd1,
        SRC_TIMER = 3'd2,
        SRC_PERF  = 3'd3,
        SRC_SOFT0 = 3'd4,
        SRC_SOFT1 = 3'd5,
        SRC_DBG   = 3'd6
    } lic_src_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_CTRL,
        K_PEND,
        K_MASK,
        K_CLR,
        K_SET,
        K_MAP
    } lic_kind_e;

    typedef struct packed {
        lic_kind_e             kind;
        logic [SRC_IDX_W-1:0]  idx;
    } lic_dec_t;

    typedef struct packed {
        logic              route_en;
        logic [PIN_W-1:0]  pin;
    } lic_map_t;

    function automatic lic_dec_t lic_decode(input logic [ADDR_W-1:0] a);
        lic_dec_t d;
        d.kind = K_NONE;
        d.idx  = '0;
        if (a[1:0] == 2'b00) begin
            if (a == OFS_CTRL)      d.kind = K_CTRL;
            else if (a == OFS_PEND) d.kind = K_PEND;
            else if (a == OFS_MASK) d.kind = K_MASK;
            else if (a == OFS_CLR)  d.kind = K_CLR;
            else if (a == OFS_SET)  d.kind = K_SET;
            else if (a >= OFS_MAP_BASE && a < OFS_MAP_END) begin
                d.kind = K_MAP;
                d.idx  = SRC_IDX_W'((a - OFS_MAP_BASE) >> 2);
            end
        end
        return d;
    endfunction

    function automatic logic [PIN_W-1:0] lic_resolve_line(input logic [PIN_W-1:0] pin,
                                                          input int max_line);
        return (pin > PIN_W'(max_line)) ? PIN_W'(max_line) : pin;
    endfunction

    function automatic logic lic_src_routable(input logic [NUM_FLAGS-1:0] flags,
                                              input int s);
        case (s)
            int'(SRC_TIMER):                     return flags[0];
            int'(SRC_PERF):                      return flags[1];
            int'(SRC_SOFT0), int'(SRC_SOFT1):    return flags[2];
            int'(SRC_DBG):                       return flags[3];
            default:                             return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/lic_regs.sv
module lic_regs
    import lic_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  lic_dec_t                  dec,
    input  logic [DATA_W-1:0]         wdata,
    output logic                      eic_q,
    output logic [NUM_SRC-1:0]        mask_q,
    output lic_map_t [NUM_SRC-1:0]    maps_q
);

    logic               set_hit;
    logic               clr_hit;
    logic [NUM_SRC-1:0] lo_bits;
    logic               unused_wdata;

    assign set_hit      = wr_en && (dec.kind == K_SET);
    assign clr_hit      = wr_en && (dec.kind == K_CLR);
    assign lo_bits      = wdata[NUM_SRC-1:0];
    assign unused_wdata = ^wdata[DATA_W-2:NUM_SRC];

    always_ff @(posedge clk) begin
        if (rst) begin
            eic_q <= 1'b0;
        end else if (wr_en && dec.kind == K_CTRL) begin
            eic_q <= wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (set_hit) begin
            mask_q <= mask_q | lo_bits;
        end else if (clr_hit) begin
            mask_q <= mask_q & ~lo_bits;
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_map
        always_ff @(posedge clk) begin
            if (rst) begin
                maps_q[s] <= '0;
            end else if (wr_en && dec.kind == K_MAP && dec.idx == SRC_IDX_W'(s)) begin
                maps_q[s].route_en <= wdata[DATA_W-1];
                maps_q[s].pin      <= wdata[PIN_W-1:0];
            end
        end
    end

    AST_SET_MASK: assert property (@(posedge clk) disable iff (rst)
        set_hit |=> ((mask_q & $past(lo_bits)) == $past(lo_bits))); // R3
    AST_CLR_MASK: assert property (@(posedge clk) disable iff (rst)
        clr_hit |=> ((mask_q & $past(lo_bits)) == '0)); // R4
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(set_hit || clr_hit) |=> $stable(mask_q)); // R5

endmodule

// File: rtl/lic_route.sv
module lic_route
    import lic_pkg::*;
#(
    parameter int NUM_LINES = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC-1:0]        src,
    input  logic [NUM_SRC-1:0]        mask,
    input  lic_map_t [NUM_SRC-1:0]    maps,
    input  logic [NUM_FLAGS-1:0]      flags,
    output logic [NUM_SRC-1:0]        pend_q,
    output logic [NUM_LINES-1:0]      irq
);

    localparam int MAX_LINE = NUM_LINES - 1;

    logic [NUM_SRC-1:0]            active;
    logic [NUM_SRC-1:0][PIN_W-1:0] line_sel;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= src;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign active[s]   = pend_q[s] & mask[s] & maps[s].route_en
                           & lic_src_routable(flags, s);
        assign line_sel[s] = lic_resolve_line(maps[s].pin, MAX_LINE);
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (active[s] && line_sel[s] == PIN_W'(l)) hit = 1'b1;
            end
        end
        assign irq[l] = hit;
    end

    AST_PEND_TRACKS_SRC: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pend_q == $past(src))); // R2
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (irq != '0) |-> ((pend_q & mask) != '0)); // R8

endmodule

// File: rtl/lic_rdata.sv
module lic_rdata
    import lic_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd_en,
    input  lic_dec_t                  dec,
    input  logic                      eic,
    input  logic [NUM_FLAGS-1:0]      flags,
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC-1:0]        mask,
    input  lic_map_t [NUM_SRC-1:0]    maps,
    output logic [DATA_W-1:0]         rdata_q
);

    logic [DATA_W-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        unique case (dec.kind)
            K_CTRL: rd_next = DATA_W'({flags, eic});
            K_PEND: rd_next = DATA_W'(pend);
            K_MASK: rd_next = DATA_W'(mask);
            K_MAP: begin
                rd_next[DATA_W-1]  = maps[dec.idx].route_en;
                rd_next[PIN_W-1:0] = maps[dec.idx].pin;
            end
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_next;
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (dec.kind == K_NONE || dec.kind == K_SET || dec.kind == K_CLR))
        |=> (rdata_q == '0)); // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata_q)); // R11

endmodule

// File: rtl/lic_local_ctrl.sv
module lic_local_ctrl
    import lic_pkg::*;
#(
    parameter int                   NUM_LINES   = 6,
    parameter logic [NUM_FLAGS-1:0] ROUTE_FLAGS = '1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_SRC-1:0]    src_lvl,
    output logic [NUM_LINES-1:0]  cpu_irq
);

    lic_dec_t                dec;
    logic                    wr_en;
    logic                    rd_en;
    logic                    eic_q;
    logic [NUM_SRC-1:0]      mask_q;
    logic [NUM_SRC-1:0]      pend_q;
    lic_map_t [NUM_SRC-1:0]  maps_q;

    assign dec   = lic_decode(bus_addr);
    assign wr_en = bus_en && bus_we;
    assign rd_en = bus_en && !bus_we;

    lic_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .dec    (dec),
        .wdata  (bus_wdata),
        .eic_q  (eic_q),
        .mask_q (mask_q),
        .maps_q (maps_q)
    );

    lic_route #(.NUM_LINES(NUM_LINES)) u_route (
        .clk    (clk),
        .rst    (rst),
        .src    (src_lvl),
        .mask   (mask_q),
        .maps   (maps_q),
        .flags  (ROUTE_FLAGS),
        .pend_q (pend_q),
        .irq    (cpu_irq)
    );

    lic_rdata u_rdata (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .dec     (dec),
        .eic     (eic_q),
        .flags   (ROUTE_FLAGS),
        .pend    (pend_q),
        .mask    (mask_q),
        .maps    (maps_q),
        .rdata_q (bus_rdata)
    );

    AST_RESET_LINES_LOW: assert property (@(posedge clk)
        rst |=> (cpu_irq == '0)); // R1

endmodule

// File: tb/lic_local_ctrl_bench.sv
`timescale 1ns/1ps
module lic_local_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  src_lvl = '0;
    logic [5:0]  cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [6:0] m_mask = '0;
    logic [6:0] m_src  = '0;
    logic       m_en  [7];
    logic [5:0] m_pin [7];

    always #2.5 clk = ~clk;

    lic_local_ctrl u_lic_local_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_lvl   (src_lvl),
        .cpu_irq   (cpu_irq)
    );

    function automatic logic [5:0] exp_lines();
        logic [5:0] r = '0;
        for (int s = 0; s < 7; s++) begin
            if (m_src[s] && m_mask[s] && m_en[s])
                r[(m_pin[s] > 6'd5) ? 5 : int'(m_pin[s])] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic drive_src(input logic [6:0] v);
        @(negedge clk);
        src_lvl = v; m_src = v;
        @(negedge clk);
    endtask

    task automatic wr_map(input int i, input logic [31:0] d);
        bus_wr(8'h40 + 8'(4 * i), d);
        m_en[i] = d[31]; m_pin[i] = d[5:0];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        for (int i = 0; i < 7; i++) begin m_en[i] = 1'b0; m_pin[i] = '0; end
        void'($urandom(32'd7331));
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check("R1 irq", 32'(cpu_irq), 32'h0);
        bus_rd(8'h00, rv); check("R1 ctrl", rv, 32'h1E);
        bus_rd(8'h08, rv); check("R1 mask", rv, 32'h0);
        for (int i = 0; i < 7; i++) begin
            bus_rd(8'h40 + 8'(4 * i), rv); check("R1 map", rv, 32'h0);
        end

        // R6 control word
        bus_wr(8'h00, 32'hFFFF_FFFF);
        bus_rd(8'h00, rv); check("R6 eic set", rv, 32'h1F);
        bus_wr(8'h00, 32'h0);
        bus_rd(8'h00, rv); check("R6 eic clr", rv, 32'h1E);

        // R3 / R4 / R5 mask handling
        bus_wr(8'h10, 32'hFFFF_FF80); m_mask = '0;
        bus_rd(8'h08, rv); check("R3 high bits ignored", rv, 32'h0);
        bus_wr(8'h10, 32'h05); m_mask = 7'h05;
        bus_rd(8'h08, rv); check("R3 set", rv, 32'h05);
        bus_wr(8'h0C, 32'h04); m_mask = 7'h01;
        bus_rd(8'h08, rv); check("R4 clear", rv, 32'h01);
        bus_wr(8'h0C, 32'hFFFF_FF80);
        bus_rd(8'h08, rv); check("R4 high bits ignored", rv, 32'h01);
        bus_wr(8'h08, 32'h7F);
        bus_rd(8'h08, rv); check("R5 mask read-only", rv, 32'h01);

        // R7 routing word fields
        wr_map(3, 32'hFFFF_FFFF);
        bus_rd(8'h4C, rv); check("R7 map fields", rv, 32'h8000_003F);
        wr_map(3, 32'h0);
        bus_rd(8'h4C, rv); check("R7 map cleared", rv, 32'h0);

        // R2 pending order and read-only
        drive_src(7'b101_0011);
        bus_rd(8'h04, rv); check("R2 pending", rv, 32'h53);
        bus_wr(8'h04, 32'h0);
        bus_rd(8'h04, rv); check("R2 pending write ignored", rv, 32'h53);
        drive_src(7'h0);

        // R8 / R10 timer source onto line 1
        bus_wr(8'h10, 32'h04); m_mask = m_mask | 7'h04;
        wr_map(2, 32'h8000_0001);
        @(negedge clk); src_lvl = 7'h04; m_src = 7'h04;
        #0.5 check("R10 before edge", 32'(cpu_irq), 32'h0);
        @(posedge clk); #1 check("R10 after edge", 32'(cpu_irq), 32'h02);
        check("R8 timer line", 32'(cpu_irq), 32'(exp_lines()));

        // R6 vectored flag leaves routing alone
        bus_wr(8'h00, 32'h1);
        check("R6 eic no effect", 32'(cpu_irq), 32'h02);
        bus_wr(8'h00, 32'h0);

        // R9 clamp
        wr_map(2, 32'h8000_0028);
        check("R9 clamp to 5", 32'(cpu_irq), 32'h20);
        // R8 routing disabled
        wr_map(2, 32'h0000_0001);
        check("R8 route off", 32'(cpu_irq), 32'h0);

        // R11 unmapped and write-only reads
        bus_rd(8'h20, rv); check("R11 unmapped", rv, 32'h0);
        bus_rd(8'h5C, rv); check("R11 past last map", rv, 32'h0);
        bus_rd(8'h42, rv); check("R11 unaligned", rv, 32'h0);
        bus_rd(8'h10, rv); check("R11 set word", rv, 32'h0);

        // R8 random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [31:0] d;
            op = int'($urandom % 4);
            d  = $urandom;
            case (op)
                0: begin bus_wr(8'h10, d); m_mask = m_mask | d[6:0]; end
                1: begin bus_wr(8'h0C, d); m_mask = m_mask & ~d[6:0]; end
                2: wr_map(int'($urandom % 7), d);
                default: drive_src(d[6:0]);
            endcase
            check("R8 random lines", 32'(cpu_irq), 32'(exp_lines()));
            if (n % 8 == 0) begin
                bus_rd(8'h04, rv); check("R2 random pending", rv, 32'(m_src));
                bus_rd(8'h08, rv); check("R3 random mask", rv, 32'(m_mask));
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule